// File: doc/BRIEF.md
# Saturating Element-Count Decrement Unit

This unit is the execute stage of a scalar instruction in a vector extension. The instruction lowers a general-purpose register by a multiple of the number of 16-bit lanes that a named lane pattern selects. The vector length is fixed when the unit is built, through a parameter. A 5-bit pattern code selects a lane count for that length. A 4-bit field plus one gives the multiplier. The product is subtracted from the source operand. The arithmetic is signed, and it clamps at the most negative value of the chosen width instead of wrapping around.

A size bit selects the operand width. With the bit clear, only the low 32 bits of the source take part, and the clamped 32-bit result is widened by sign extension. With the bit set, the whole 64-bit value is used. Pattern codes that name no pattern, and fixed counts that exceed the available lanes, give a count of zero and raise no fault. A request presented with its strobe produces its result one clock later, marked by a valid flag.

Top module: `cnt_dec_sat`

## Requirements
- R1: Pattern code 31 (all lanes) gives a count of VLEN_BITS/16.
- R2: The multiplier is the 4-bit field value plus one (1 to 16). The amount subtracted is count times multiplier.
- R3: Codes 1 to 8 give fixed counts 1 to 8. Codes 9, 10, 11, 12 and 13 give 16, 32, 64, 128 and 256. Each fixed count applies only when it does not exceed the available lanes. Otherwise the count is zero.
- R4: Code 0 gives the largest power of two not above the available lane count.
- R5: Code 29 gives the lane count rounded down to a multiple of four. Code 30 rounds it down to a multiple of three.
- R6: Codes 14 to 28 give a count of zero, so the output equals the width-adjusted operand.
- R7: With the size bit at 1, the 64-bit source is reduced with signed arithmetic and clamped at -2^63.
- R8: With the size bit at 0, the upper 32 source bits are ignored. The result is clamped at -2^31 and written as its 64-bit sign extension.
- R9: A request taken with in_valid high at a rising edge drives out_valid high after that edge, with the result. A low in_valid drives out_valid low after the edge.
- R10: A synchronous reset clears out_valid at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| src | input | 64 | Source operand |
| pat | input | 5 | Lane pattern code |
| mul_field | input | 4 | Multiplier minus one |
| wide | input | 1 | 1 selects 64-bit operation, 0 selects 32-bit |
| out_valid | output | 1 | Result valid |
| out_result | output | 64 | Clamped, width-adjusted result |

## Verification
A wrong lane count from the pattern decoder changes the subtracted amount in proportion to the multiplier. It therefore shows up in the result that follows the faulty request, one clock after the strobe. A sweep of every pattern code at several multipliers exposes it. Faults in clamping or width selection appear only near the negative limits or when the upper source bits carry unrelated data. For this reason the random operands gather around -2^63 and -2^31 and carry random upper halves. A fault in the valid path shows in the very next cycle as a missing or stray out_valid.

// File: rtl/cnt_dec_sat_pkg.sv
package cnt_dec_sat_pkg;
    localparam int DATA_W = 64;
    localparam int NARROW_W = 32;

    localparam logic [4:0] PAT_POW2 = 5'd0;
    localparam logic [4:0] PAT_MUL4 = 5'd29;
    localparam logic [4:0] PAT_MUL3 = 5'd30;
    localparam logic [4:0] PAT_ALL  = 5'd31;

    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] res;
    } wb_t;
endpackage

// File: rtl/lane_cnt_dec.sv
module lane_cnt_dec
    import cnt_dec_sat_pkg::*;
#(
    parameter int ELEMS = 16,
    parameter int CNT_W = 5
) (
    input  logic [4:0]       pat,
    output logic [CNT_W-1:0] cnt
);
    function automatic int floor_pow2(input int n);
        int r;
        r = 0;
        for (int i = 0; i < 16; i++) begin
            if ((1 << i) <= n) r = 1 << i;
        end
        return r;
    endfunction

    localparam int POW2_N = floor_pow2(ELEMS);
    localparam int MUL3_N = ELEMS - (ELEMS % 3);
    localparam int MUL4_N = ELEMS - (ELEMS % 4);

    logic [9:0] fixed_n;

    always_comb begin
        fixed_n = '0;
        if (pat >= 5'd1 && pat <= 5'd8)
            fixed_n = 10'(pat);
        else if (pat >= 5'd9 && pat <= 5'd13)
            fixed_n = 10'd16 << (pat - 5'd9);

        cnt = '0;
        case (pat)
            PAT_POW2: cnt = CNT_W'(POW2_N);
            PAT_MUL4: cnt = CNT_W'(MUL4_N);
            PAT_MUL3: cnt = CNT_W'(MUL3_N);
            PAT_ALL:  cnt = CNT_W'(ELEMS);
            default: begin
                if (fixed_n != '0 && fixed_n <= 10'(ELEMS))
                    cnt = CNT_W'(fixed_n);
            end
        endcase
    end
endmodule

// File: rtl/clamp_sub.sv
module clamp_sub
    import cnt_dec_sat_pkg::*;
#(
    parameter int PROD_W = 10
) (
    input  logic [DATA_W-1:0] src,
    input  logic [PROD_W-1:0] amount,
    input  logic              wide,
    output logic [DATA_W-1:0] res
);
    localparam int EXT_W = DATA_W + 1;

    logic signed [EXT_W-1:0] opnd;
    logic signed [EXT_W-1:0] diff;
    logic                    under64;
    logic                    under32;

    always_comb begin
        opnd = wide ? $signed({src[DATA_W-1], src})
                    : $signed({{(EXT_W-NARROW_W){src[NARROW_W-1]}}, src[NARROW_W-1:0]});
        diff = opnd - $signed({{(EXT_W-PROD_W){1'b0}}, amount});
        under64 = diff[EXT_W-1] != diff[DATA_W-1];
        under32 = !((&diff[EXT_W-1:NARROW_W-1]) || (~|diff[EXT_W-1:NARROW_W-1]));
        if (wide)
            res = under64 ? {1'b1, {(DATA_W-1){1'b0}}} : diff[DATA_W-1:0];
        else
            res = under32 ? {{(DATA_W-NARROW_W+1){1'b1}}, {(NARROW_W-1){1'b0}}}
                          : diff[DATA_W-1:0];
    end
endmodule

// File: rtl/cnt_dec_sat.sv
module cnt_dec_sat
    import cnt_dec_sat_pkg::*;
#(
    parameter int VLEN_BITS = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [63:0]       src,
    input  logic [4:0]        pat,
    input  logic [3:0]        mul_field,
    input  logic              wide,
    output logic              out_valid,
    output logic [63:0]       out_result
);
    localparam int ELEMS  = VLEN_BITS / 16;
    localparam int CNT_W  = $clog2(ELEMS + 1);
    localparam int PROD_W = CNT_W + 5;

    logic [CNT_W-1:0]  lane_cnt;
    logic [4:0]        mult;
    logic [PROD_W-1:0] amount;
    logic [DATA_W-1:0] sat_res;
    wb_t               wb_d, wb_q;

    lane_cnt_dec #(.ELEMS(ELEMS), .CNT_W(CNT_W)) u_dec (
        .pat (pat),
        .cnt (lane_cnt)
    );

    always_comb begin
        mult   = {1'b0, mul_field} + 5'd1;
        amount = PROD_W'(lane_cnt) * PROD_W'(mult);
    end

    clamp_sub #(.PROD_W(PROD_W)) u_sub (
        .src    (src),
        .amount (amount),
        .wide   (wide),
        .res    (sat_res)
    );

    always_comb begin
        wb_d     = wb_q;
        wb_d.vld = in_valid;
        if (in_valid) wb_d.res = sat_res;
        if (rst) wb_d = '0;
    end

    always_ff @(posedge clk) begin
        wb_q <= wb_d;
    end

    assign out_valid  = wb_q.vld;
    assign out_result = wb_q.res;

    p_count_bound_r1: assert property (@(posedge clk) disable iff (rst)
        32'(lane_cnt) <= ELEMS);
    p_pow2_onehot_r4: assert property (@(posedge clk) disable iff (rst)
        (pat == PAT_POW2) |-> $onehot0(lane_cnt));
    p_unalloc_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (pat >= 5'd14 && pat <= 5'd28) |-> (lane_cnt == '0));
    p_no_wrap_r7: assert property (@(posedge clk) disable iff (rst)
        wide |-> ($signed(sat_res) <= $signed(src)));
    p_sign_ext_r8: assert property (@(posedge clk) disable iff (rst)
        !wide |-> ((&sat_res[63:31]) || (~|sat_res[63:31])));
    p_valid_set_r9: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_valid_clr_r9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    p_reset_clear_r10: assert property (@(posedge clk)
        rst |=> !out_valid);
endmodule

// File: tb/cnt_dec_sat_test.sv
module cnt_dec_sat_test;
    localparam int VLEN = 640;
    localparam int EL = VLEN / 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [63:0] src = '0;
    logic [4:0]  pat = '0;
    logic [3:0]  mul_field = '0;
    logic        wide = 1'b0;
    logic        out_valid;
    logic [63:0] out_result;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    cnt_dec_sat #(.VLEN_BITS(VLEN)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .src(src), .pat(pat),
        .mul_field(mul_field), .wide(wide), .out_valid(out_valid),
        .out_result(out_result)
    );

    function automatic int exp_cnt(input int p);
        int n, r;
        n = 0;
        if (p == 0) begin
            r = 1;
            while (r * 2 <= EL) r = r * 2;
            return r;
        end
        if (p == 29) return EL - EL % 4;
        if (p == 30) return EL - EL % 3;
        if (p == 31) return EL;
        if (p >= 1 && p <= 8) n = p;
        else if (p >= 9 && p <= 13) n = 16 << (p - 9);
        return (n <= EL) ? n : 0;
    endfunction

    function automatic logic [63:0] exp_res(input logic [63:0] s, input int p,
                                            input int m, input logic w);
        logic signed [127:0] op, d, lim;
        op  = w ? $signed({{64{s[63]}}, s}) : $signed({{96{s[31]}}, s[31:0]});
        d   = op - $signed(128'(exp_cnt(p) * (m + 1)));
        lim = w ? -(128'sd1 <<< 63) : -(128'sd1 <<< 31);
        if (d < lim) d = lim;
        return d[63:0];
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic apply(input string tag, input logic [63:0] s, input int p,
                         input int m, input logic w);
        @(negedge clk);
        in_valid = 1'b1; src = s; pat = 5'(p); mul_field = 4'(m); wide = w;
        @(negedge clk);
        check("R9 valid", 64'(out_valid), 64'd1);
        check(tag, out_result, exp_res(s, p, m, w));
    endtask

    initial begin
        #1000000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] s;
        int p, m;
        logic w;
        void'($urandom(42));
        repeat (3) @(negedge clk);
        check("R10 reset valid", 64'(out_valid), 64'd0);
        rst = 1'b0;

        // R1 all lanes, R2 multiplier
        apply("R1 all", 64'd1000, 31, 0, 1'b1);
        check("R1 value", out_result, 64'd960);
        apply("R2 mul16", 64'd1000, 31, 15, 1'b1);
        check("R2 value", out_result, 64'd360);
        // R4 pow2 = 32, R5 mul3 = 39, mul4 = 40
        apply("R4 pow2", 64'd100, 0, 0, 1'b1);
        check("R4 value", out_result, 64'd68);
        apply("R5 mul3", 64'd100, 30, 0, 1'b1);
        check("R5 value", out_result, 64'd61);
        apply("R5 mul4", 64'd100, 29, 1, 1'b1);
        check("R5 mul4 value", out_result, 64'd20);
        // R3 fixed counts: VL32 fits, VL64 does not
        apply("R3 vl32", 64'd100, 10, 0, 1'b0);
        check("R3 vl32 value", out_result, 64'd68);
        apply("R3 vl64", 64'd100, 11, 3, 1'b0);
        check("R3 vl64 zero", out_result, 64'd100);
        apply("R3 vl7", 64'd100, 7, 2, 1'b1);
        // R6 unallocated
        apply("R6 code20", 64'h1234_5678_9abc_def0, 20, 15, 1'b1);
        check("R6 unchanged", out_result, 64'h1234_5678_9abc_def0);
        // R7 clamp at -2^63
        apply("R7 clamp", 64'h8000_0000_0000_0005, 31, 15, 1'b1);
        check("R7 min", out_result, 64'h8000_0000_0000_0000);
        // R8 upper ignored, clamp at -2^31, sign extension
        apply("R8 upper", {32'hffff_0000, 32'd100}, 31, 0, 1'b0);
        check("R8 value", out_result, 64'd60);
        apply("R8 clamp", {32'hdead_beef, 32'h8000_0001}, 31, 0, 1'b0);
        check("R8 min", out_result, 64'hffff_ffff_8000_0000);
        apply("R8 negext", {32'h0, 32'hffff_fff0}, 31, 0, 1'b0);
        check("R8 ext", out_result, 64'hffff_ffff_ffff_ffc8);

        for (int c = 0; c < 32; c++) apply("R3 sweep", 64'd5000, c, c % 16, c[0]);

        for (int i = 0; i < 400; i++) begin
            case ($urandom % 4)
                0: s = {$urandom, $urandom};
                1: s = 64'h8000_0000_0000_0000 + 64'($urandom % 4096);
                2: s = {$urandom, 32'h8000_0000 + ($urandom % 4096)};
                default: s = 64'($urandom % 3000);
            endcase
            p = int'($urandom % 32);
            m = int'($urandom % 16);
            w = 1'($urandom % 2);
            apply(w ? "R7 random" : "R8 random", s, p, m, w);
        end

        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        check("R9 idle", 64'(out_valid), 64'd0);

        in_valid = 1'b1;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R10 sync reset", 64'(out_valid), 64'd0);
        rst = 1'b0;
        in_valid = 1'b0;

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule